// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a small serial-bus master that waits for a two-wire EEPROM to finish its internal write cycle. A pulse on `trigger` starts it, typically right after the stop that closed the write command. From then on it probes the target repeatedly. Each probe is a start condition followed by a control byte: the 7-bit target address, then a direction bit of 0 (write). The master then releases SDA for the ninth clock and reads the target's answer.

If SDA is high in that slot, the target did not acknowledge and is still busy. The block then sends a stop and begins another probe. If SDA is low, the write cycle is over. The block then raises `ready`. By default it keeps SCL pulled low so that the following command can carry on without a stop. With `STOP_ON_ACK` set, it sends a stop first and leaves the bus idle. A probe budget of `MAX_POLLS` caps the search. When that budget is spent, the block ends with a stop and raises `timeoutErr`.

Both bus lines are open drain. The outputs are pull-low enables, and `sdaIn` is the resolved level of the SDA wire. Each SCL bit time is four quarter phases, and each quarter lasts `DIV` clock cycles.

Top module: `ack_poll_master`

## Requirements
- R1: While reset is held and after it is released, both pull-low enables are 0 and `ready` and `timeoutErr` are 0 until a trigger arrives.
- R2: Every probe opens with SDA falling while SCL is high. Eight bits follow, most significant first: `targetAddr[6]` down to `targetAddr[0]`, then a 0 as the eighth bit.
- R3: Apart from start and stop conditions, SDA only changes while SCL is low.
- R4: During the ninth SCL pulse of a probe the master does not pull SDA low. The acknowledge level is taken at the clock edge on which SCL is released for that pulse.
- R5: A high acknowledge level causes a stop condition (SDA rising while SCL is high), followed by a new probe.
- R6: With `STOP_ON_ACK` = 0, a low acknowledge level raises `ready` with no stop. SCL is then held low and SDA is released.
- R7: With `STOP_ON_ACK` = 1, a low acknowledge level is followed by a stop condition. After it, `ready` is 1 and both lines are released.
- R8: Once `MAX_POLLS` probes have all been refused, the block issues a stop and raises `timeoutErr`, not `ready`. It begins no further probes.
- R9: Within a probe, successive SCL rising edges are exactly 4·`DIV` clock cycles apart.
- R10: A trigger that arrives while a probe sequence is running has no effect. A trigger while `ready` or `timeoutErr` is high starts a fresh sequence with the full probe budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | One-cycle request to begin polling |
| targetAddr | input | 7 | Address of the target to probe |
| sdaIn | input | 1 | Resolved level of the SDA wire |
| sclLowEn | output | 1 | 1 pulls SCL low |
| sdaLowEn | output | 1 | 1 pulls SDA low |
| ready | output | 1 | Target acknowledged; next command may proceed |
| timeoutErr | output | 1 | Probe budget exhausted without acknowledge |

## Verification
The assertions assume that `sdaIn` only reflects a target that drives SDA low in the acknowledge slot. They also assume that `targetAddr` stays constant from trigger until the result flags. The bench target model changes its SDA pull only on SCL falling edges, and the bench changes the address only between runs. The sweep covers every busy length from zero up to one beyond the probe budget. It runs the hold and stop variants side by side, and it injects a stray trigger in the middle of every sequence.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_START,
    PS_BIT,
    PS_ACK,
    PS_STOP,
    PS_HOLD,
    PS_READY,
    PS_TIMEOUT
  } pollState_t;

  typedef struct packed {
    logic runDiv;
    logic loadShift;
    logic shiftNext;
    logic sampleAck;
    logic clrPoll;
    logic incPoll;
  } pollStrobes_t;

endpackage

// File: rtl/ack_poll_datapath.sv
module ack_poll_datapath
  import ack_poll_pkg::*;
#(
  parameter int DIV       = 125,
  parameter int MAX_POLLS = 255
) (
  input  logic         clk,
  input  logic         rstN,
  input  pollStrobes_t strb,
  input  logic [6:0]   targetAddr,
  input  logic         sdaIn,
  output logic         tick,
  output logic [1:0]   phase,
  output logic         txBit,
  output logic         lastBit,
  output logic         ackBit,
  output logic         pollsDone
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  // quarter-phase tick generator
  generate
    if (DIV == 1) begin : g_noDiv
      assign tick = strb.runDiv;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !strb.runDiv) divCnt <= '0;
        else if (divCnt == DW'(DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = strb.runDiv && (divCnt == DW'(DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || !strb.runDiv) phase <= 2'd0;
    else if (tick) phase <= phase + 2'd1;
  end

  // control byte shifter
  logic [7:0] shiftReg;
  logic [2:0] bitCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.loadShift) begin
      shiftReg <= {targetAddr, 1'b0};
      bitCnt   <= '0;
    end else if (strb.shiftNext) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
      bitCnt   <= bitCnt + 3'd1;
    end
  end
  assign txBit   = shiftReg[7];
  assign lastBit = (bitCnt == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) ackBit <= 1'b1;
    else if (strb.sampleAck) ackBit <= sdaIn;
  end

  // probe budget
  logic [PW-1:0] pollCnt;
  always_ff @(posedge clk) begin
    if (!rstN) pollCnt <= '0;
    else if (strb.clrPoll) pollCnt <= PW'(1);
    else if (strb.incPoll) pollCnt <= pollCnt + 1'b1;
  end
  assign pollsDone = (pollCnt == PW'(MAX_POLLS));

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PW'(MAX_POLLS));

  assert_load_write_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShift |=> (shiftReg[0] == 1'b0 && bitCnt == 3'd0));

endmodule

// File: rtl/ack_poll_ctrl.sv
module ack_poll_ctrl
  import ack_poll_pkg::*;
#(
  parameter bit STOP_ON_ACK = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigger,
  input  logic         tick,
  input  logic [1:0]   phase,
  input  logic         txBit,
  input  logic         lastBit,
  input  logic         ackBit,
  input  logic         pollsDone,
  output pollStrobes_t strb,
  output logic         sclLowEn,
  output logic         sdaLowEn,
  output logic         ready,
  output logic         timeoutErr
);
  pollState_t state, nextState;
  logic phaseEnd, sclHighPhase;

  assign phaseEnd     = tick && (phase == 2'd3);
  assign sclHighPhase = (phase == 2'd1) || (phase == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    strb.runDiv = (state == PS_START) || (state == PS_BIT) ||
                  (state == PS_ACK) || (state == PS_STOP);
    case (state)
      PS_IDLE, PS_HOLD, PS_READY, PS_TIMEOUT: begin
        if (trigger) begin
          nextState      = PS_START;
          strb.loadShift = 1'b1;
          strb.clrPoll   = 1'b1;
        end
      end
      PS_START: if (phaseEnd) nextState = PS_BIT;
      PS_BIT: begin
        if (phaseEnd) begin
          strb.shiftNext = 1'b1;
          if (lastBit) nextState = PS_ACK;
        end
      end
      PS_ACK: begin
        strb.sampleAck = tick && (phase == 2'd0);
        if (phaseEnd) begin
          if (!ackBit && !STOP_ON_ACK) nextState = PS_HOLD;
          else nextState = PS_STOP;
        end
      end
      PS_STOP: begin
        if (phaseEnd) begin
          if (!ackBit) nextState = PS_READY;
          else if (pollsDone) nextState = PS_TIMEOUT;
          else begin
            nextState      = PS_START;
            strb.loadShift = 1'b1;
            strb.incPoll   = 1'b1;
          end
        end
      end
      default: nextState = PS_IDLE;
    endcase
  end

  always_comb begin
    sclLowEn = 1'b0;
    sdaLowEn = 1'b0;
    case (state)
      PS_START: begin
        sclLowEn = (phase == 2'd0) || (phase == 2'd3);
        sdaLowEn = phase[1];
      end
      PS_BIT: begin
        sclLowEn = !sclHighPhase;
        sdaLowEn = !txBit;
      end
      PS_ACK:  sclLowEn = !sclHighPhase;
      PS_STOP: begin
        sclLowEn = (phase == 2'd0);
        sdaLowEn = !phase[1];
      end
      PS_HOLD: sclLowEn = 1'b1;
      default: ;
    endcase
  end

  assign ready      = (state == PS_HOLD) || (state == PS_READY);
  assign timeoutErr = (state == PS_TIMEOUT);

  assert_sda_quiet_scl_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLowEn && $past(!sclLowEn) && state != PS_START && state != PS_STOP)
      |-> $stable(sdaLowEn));

  assert_dir_bit_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_BIT && lastBit) |-> sdaLowEn);

  assert_hold_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_ACK && phaseEnd && !ackBit && !STOP_ON_ACK) |=> (ready && sclLowEn && !sdaLowEn));

  assert_timeout_needs_budget_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> pollsDone);

  assert_busy_ignores_trigger_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && state == PS_BIT && !phaseEnd) |=> state == PS_BIT);

endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
  import ack_poll_pkg::*;
#(
  parameter int DIV         = 125,
  parameter int MAX_POLLS   = 255,
  parameter bit STOP_ON_ACK = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  logic [6:0] targetAddr,
  input  logic       sdaIn,
  output logic       sclLowEn,
  output logic       sdaLowEn,
  output logic       ready,
  output logic       timeoutErr
);
  pollStrobes_t strb;
  logic tick, txBit, lastBit, ackBit, pollsDone;
  logic [1:0] phase;

  ack_poll_ctrl #(.STOP_ON_ACK(STOP_ON_ACK)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .tick(tick), .phase(phase),
    .txBit(txBit), .lastBit(lastBit), .ackBit(ackBit), .pollsDone(pollsDone),
    .strb(strb), .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn),
    .ready(ready), .timeoutErr(timeoutErr)
  );

  ack_poll_datapath #(.DIV(DIV), .MAX_POLLS(MAX_POLLS)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .targetAddr(targetAddr), .sdaIn(sdaIn),
    .tick(tick), .phase(phase), .txBit(txBit), .lastBit(lastBit),
    .ackBit(ackBit), .pollsDone(pollsDone)
  );

endmodule

// File: tb/ack_poll_master_bench.sv
module ack_poll_target_model (
  input  logic clk,
  input  logic clr,
  input  logic sclLowEn,
  input  logic sdaLowEn,
  input  int   busyPolls,
  output logic sdaIn
);
  logic tgtLow = 1'b0;
  logic prevScl = 1'b1, prevSda = 1'b1, inFrame = 1'b0;
  logic [7:0] shiftByte = '0;
  int bitIdx = 0, cyc = 0, lastRise = 0;
  int starts = 0, stops = 0, attempts = 0, badPeriods = 0, masterDrove = 0;
  int ackLowSeen = 0;
  logic [7:0] lastByte = '0;
  logic scl, sda;

  assign scl   = !sclLowEn;
  assign sda   = !(sdaLowEn || tgtLow);
  assign sdaIn = sda;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prevScl <= scl;
    prevSda <= sda;
    if (clr) begin
      starts <= 0; stops <= 0; attempts <= 0; badPeriods <= 0;
      masterDrove <= 0; ackLowSeen <= 0; inFrame <= 1'b0; tgtLow <= 1'b0;
      lastByte <= '0;
    end else begin
      if (scl && prevScl && prevSda && !sda) begin
        starts <= starts + 1; inFrame <= 1'b1; bitIdx <= 0; shiftByte <= '0;
      end else if (scl && prevScl && !prevSda && sda) begin
        stops <= stops + 1; inFrame <= 1'b0;
      end else if (inFrame && !prevScl && scl) begin
        if (bitIdx < 8) shiftByte <= {shiftByte[6:0], sda};
        if (bitIdx == 8) begin
          if (sdaLowEn) masterDrove <= masterDrove + 1;
          if (!sda) ackLowSeen <= ackLowSeen + 1;
        end
        if (bitIdx >= 1 && bitIdx <= 8 && (cyc - lastRise) != 8) badPeriods <= badPeriods + 1;
        lastRise <= cyc;
        bitIdx <= bitIdx + 1;
      end else if (inFrame && prevScl && !scl) begin
        if (bitIdx == 8) begin
          lastByte <= shiftByte;
          attempts <= attempts + 1;
          tgtLow <= (attempts + 1) > busyPolls;
        end
        if (bitIdx == 9) tgtLow <= 1'b0;
      end
    end
  end
endmodule

module ack_poll_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIVB = 2;
  localparam int MAXP = 4;

  logic clk = 1'b0, rstN = 1'b0, trigger = 1'b0, clr = 1'b0;
  logic [6:0] addr = '0;
  int busy = 0;
  int checks = 0, errors = 0, cycles = 0;
  logic sdaH, sclLH, sdaLH, rdyH, toH;
  logic sdaS, sclLS, sdaLS, rdyS, toS;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_poll_master #(.DIV(DIVB), .MAX_POLLS(MAXP), .STOP_ON_ACK(1'b0)) u_ack_poll_master (
    .clk(clk), .rstN(rstN), .trigger(trigger), .targetAddr(addr), .sdaIn(sdaH),
    .sclLowEn(sclLH), .sdaLowEn(sdaLH), .ready(rdyH), .timeoutErr(toH));
  ack_poll_master #(.DIV(DIVB), .MAX_POLLS(MAXP), .STOP_ON_ACK(1'b1)) u_ack_poll_master_stop (
    .clk(clk), .rstN(rstN), .trigger(trigger), .targetAddr(addr), .sdaIn(sdaS),
    .sclLowEn(sclLS), .sdaLowEn(sdaLS), .ready(rdyS), .timeoutErr(toS));

  ack_poll_target_model u_modelH (.clk(clk), .clr(clr), .sclLowEn(sclLH), .sdaLowEn(sdaLH),
    .busyPolls(busy), .sdaIn(sdaH));
  ack_poll_target_model u_modelS (.clk(clk), .clr(clr), .sclLowEn(sclLS), .sdaLowEn(sdaLS),
    .busyPolls(busy), .sdaIn(sdaS));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary();
    end
  end

  task automatic doRun(input int b, input logic [6:0] a);
    int n;
    bit expReady;
    @(negedge clk);
    busy = b; addr = a; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (40) @(negedge clk);
    trigger = 1'b1;  // stray trigger mid-sequence, R10
    @(negedge clk);
    trigger = 1'b0;
    n = 0;
    while (!((rdyH || toH) && (rdyS || toS)) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (60) @(negedge clk);
    expReady = (b < MAXP);
    chk("R6 hold ready", rdyH, expReady);
    chk("R7 stop ready", rdyS, expReady);
    chk("R8 hold timeout", toH, !expReady);
    chk("R8 stop timeout", toS, !expReady);
    chk("R5 hold starts", u_modelH.starts, expReady ? b + 1 : MAXP);
    chk("R5 stop starts", u_modelS.starts, expReady ? b + 1 : MAXP);
    chk("R5 hold stops", u_modelH.stops, expReady ? b : MAXP);
    chk("R7 stop stops", u_modelS.stops, expReady ? b + 1 : MAXP);
    chk("R2 hold byte", u_modelH.lastByte, {a, 1'b0});
    chk("R2 stop byte", u_modelS.lastByte, {a, 1'b0});
    chk("R4 hold master released ack slot", u_modelH.masterDrove, 0);
    chk("R4 stop ack seen", u_modelS.ackLowSeen, expReady ? 1 : 0);
    chk("R9 hold scl period", u_modelH.badPeriods, 0);
    chk("R9 stop scl period", u_modelS.badPeriods, 0);
    chk("R6 hold scl held low", sclLH, expReady);
    chk("R6 hold sda released", sdaLH, 0);
    chk("R7 stop bus released", {sclLS, sdaLS}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset scl", sclLH | sclLS, 0);
    chk("R1 reset sda", sdaLH | sdaLS, 0);
    chk("R1 reset flags", {rdyH, toH, rdyS, toS}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", {sclLH, sdaLH, rdyH, toH, sclLS, sdaLS, rdyS, toS}, 0);
    for (int b = 0; b <= MAXP + 1; b++) begin
      doRun(b, 7'(7'h50 + b * 23));
    end
    // fresh budget after a timeout, R10
    doRun(MAXP - 1, 7'h2A);
    doRun(0, 7'h7F);
    doRun(1, 7'h00);
    summary();
  end
endmodule